// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the integer execute stage of a three-operand load/store processor. Each cycle it accepts two 32-bit register operands, a 16-bit instruction immediate, a 5-bit shift count and a 5-bit operation code. It produces one 32-bit result, which is captured in an output register on the next rising clock edge. One adder serves addition, subtraction and both magnitude comparisons. A logarithmic barrel shifter serves the three shift kinds. The immediate is widened inside the unit: zero-fill for the bitwise forms, sign-fill for the arithmetic and compare forms.

The pipeline drives the operation code and operands every cycle and takes the registered result one cycle later. Additions and subtractions wrap modulo 2^32. The unit raises no overflow trap and produces no flag. Codes outside the defined set give zero, so a squashed or undefined slot writes back a harmless value.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` becomes 0. Otherwise `result_o` takes, on each rising edge, the result for the inputs present just before that edge (one-cycle latency).
- R2: Code 0 gives src_a+src_b and code 1 gives src_a−src_b. Code 10 gives src_a plus the sign-extended immediate. All three wrap modulo 2^32.
- R3: Code 2 gives src_a AND src_b, code 3 gives src_a OR src_b, and code 4 gives the complement of (src_a OR src_b).
- R4: Code 11 gives src_a AND the immediate, and code 12 gives src_a OR the immediate. In both, the immediate is zero-extended, so bits 31..16 of the AND form are always 0.
- R5: Code 5 shifts src_a left and code 6 shifts src_a right, each by `shamt_i` (0 to 31), with zeros filling the vacated bits.
- R6: Code 7 shifts src_a right by `shamt_i`, filling the vacated bits with copies of src_a bit 31.
- R7: Code 8 gives 1 if src_a < src_b as two's-complement values and 0 otherwise. Code 9 does the same comparison as unsigned values. For src_a=0xFFFFFFFA and src_b=0x0000FFFA, code 8 gives 1 and code 9 gives 0.
- R8: Code 13 compares src_a with the sign-extended immediate as signed values, and code 14 compares them as unsigned values. Each gives 1 if src_a is less and 0 otherwise.
- R9: Code 15 places the immediate in bits 31..16 and clears bits 15..0. Neither src_a nor src_b has any effect on this result.
- R10: Codes 16 to 31 give a result of 0 whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_i | input | 5 | Operation code (see requirements) |
| src_a_i | input | 32 | First register operand; also the value that is shifted |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Shift count |
| result_o | output | 32 | Registered result |

## Verification
The hardest cases to reach are at the extremes of the shared adder and the shifter. These include signed comparisons whose operands have opposite signs, where the difference alone gives the wrong answer. They also include unsigned comparisons against an immediate whose sign bit is set, which extends to a very large value. A third case is the arithmetic shift by 31 of a negative value. Random operands seldom land on these, so the stimulus includes directed operand pairs around 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and immediates of 0x8000 and 0xFFFF. It also sweeps every shift count for positive and negative inputs and mixes in equal-operand pairs, all alongside a pseudo-random pass over every code, undefined codes included.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_NOR   = 5'd4,
    OP_SLL   = 5'd5,
    OP_SRL   = 5'd6,
    OP_SRA   = 5'd7,
    OP_LTS   = 5'd8,
    OP_LTU   = 5'd9,
    OP_ADDI  = 5'd10,
    OP_ANDI  = 5'd11,
    OP_ORI   = 5'd12,
    OP_LTSI  = 5'd13,
    OP_LTUI  = 5'd14,
    OP_UPPER = 5'd15
  } ieu_op_e;

  // Which value feeds the second operand path
  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_SEXT = 2'd1,
    BSRC_ZEXT = 2'd2
  } bsrc_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } shift_e;

  typedef enum logic [2:0] {
    RES_ZERO  = 3'd0,
    RES_SUM   = 3'd1,
    RES_AND   = 3'd2,
    RES_OR    = 3'd3,
    RES_NOR   = 3'd4,
    RES_SHIFT = 3'd5,
    RES_LT    = 3'd6,
    RES_UPPER = 3'd7
  } res_e;

  typedef struct packed {
    bsrc_e  bsrc;
    logic   sub;
    logic   lt_unsigned;
    shift_e shmode;
    res_e   rsel;
  } ctl_t;

endpackage

// File: rtl/ieu_decode.sv
module ieu_decode
  import ieu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);

  always_comb begin
    ctl_o             = '0;
    ctl_o.bsrc        = BSRC_REG;
    ctl_o.shmode      = SH_LEFT;
    ctl_o.rsel        = RES_ZERO;
    case (op_i)
      OP_ADD:  ctl_o.rsel = RES_SUM;
      OP_SUB: begin
        ctl_o.sub  = 1'b1;
        ctl_o.rsel = RES_SUM;
      end
      OP_AND:  ctl_o.rsel = RES_AND;
      OP_OR:   ctl_o.rsel = RES_OR;
      OP_NOR:  ctl_o.rsel = RES_NOR;
      OP_SLL: begin
        ctl_o.shmode = SH_LEFT;
        ctl_o.rsel   = RES_SHIFT;
      end
      OP_SRL: begin
        ctl_o.shmode = SH_RLOG;
        ctl_o.rsel   = RES_SHIFT;
      end
      OP_SRA: begin
        ctl_o.shmode = SH_RARI;
        ctl_o.rsel   = RES_SHIFT;
      end
      OP_LTS: begin
        ctl_o.sub  = 1'b1;
        ctl_o.rsel = RES_LT;
      end
      OP_LTU: begin
        ctl_o.sub         = 1'b1;
        ctl_o.lt_unsigned = 1'b1;
        ctl_o.rsel        = RES_LT;
      end
      OP_ADDI: begin
        ctl_o.bsrc = BSRC_SEXT;
        ctl_o.rsel = RES_SUM;
      end
      OP_ANDI: begin
        ctl_o.bsrc = BSRC_ZEXT;
        ctl_o.rsel = RES_AND;
      end
      OP_ORI: begin
        ctl_o.bsrc = BSRC_ZEXT;
        ctl_o.rsel = RES_OR;
      end
      OP_LTSI: begin
        ctl_o.bsrc = BSRC_SEXT;
        ctl_o.sub  = 1'b1;
        ctl_o.rsel = RES_LT;
      end
      OP_LTUI: begin
        ctl_o.bsrc        = BSRC_SEXT;
        ctl_o.sub         = 1'b1;
        ctl_o.lt_unsigned = 1'b1;
        ctl_o.rsel        = RES_LT;
      end
      OP_UPPER: ctl_o.rsel = RES_UPPER;
      default:  ctl_o.rsel = RES_ZERO;
    endcase
  end

endmodule

// File: rtl/ieu_opnd_sel.sv
module ieu_opnd_sel
  import ieu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  bsrc_e             bsrc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opnd_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;

  assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zext = {{EXT_W{1'b0}}, imm_i};

  always_comb begin
    case (bsrc_i)
      BSRC_SEXT: opnd_o = imm_sext;
      BSRC_ZEXT: opnd_o = imm_zext;
      default:   opnd_o = reg_i;
    endcase
  end

endmodule

// File: rtl/ieu_addsub.sv
module ieu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_signed_o,
  output logic              lt_unsigned_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_x;
  logic [DATA_W:0]   full;

  assign b_x  = sub_i ? ~b_i : b_i;
  assign full = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub_i};

  assign sum_o = full[MSB:0];

  // a < b unsigned exactly when a - b borrows (no carry out)
  assign lt_unsigned_o = ~full[DATA_W];

  // differing signs: the negative operand is the smaller; else sign of difference
  assign lt_signed_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : full[MSB];

endmodule

// File: rtl/ieu_shift.sv
module ieu_shift
  import ieu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  shift_e            mode_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int MSB = DATA_W - 1;

  logic              left;
  logic              fill;
  logic [DATA_W-1:0] pre;
  logic [DATA_W-1:0] post;
  logic [DATA_W-1:0] stage [0:SH_W];

  assign left = (mode_i == SH_LEFT);
  assign fill = (mode_i == SH_RARI) & val_i[MSB];

  // Left shifts reuse the right-shift network on a bit-reversed word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign pre[i]   = left ? val_i[MSB-i] : val_i[i];
    assign res_o[i] = left ? post[MSB-i]  : post[i];
  end

  assign stage[0] = pre;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{fill}}, stage[s][MSB:STEP]} : stage[s];
  end

  assign post = stage[SH_W];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int IMM_W  = 16,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] result_o
);

  localparam int LOW_W = DATA_W - IMM_W;

  ctl_t              ctl;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic              lt_s;
  logic              lt_u;
  logic              lt_bit;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] res_d;

  ieu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  ieu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .bsrc_i (ctl.bsrc),
    .reg_i  (src_b_i),
    .imm_i  (imm_i),
    .opnd_o (opnd_b)
  );

  ieu_addsub #(.DATA_W(DATA_W)) u_add (
    .sub_i         (ctl.sub),
    .a_i           (src_a_i),
    .b_i           (opnd_b),
    .sum_o         (sum),
    .lt_signed_o   (lt_s),
    .lt_unsigned_o (lt_u)
  );

  ieu_shift #(.DATA_W(DATA_W)) u_shf (
    .mode_i (ctl.shmode),
    .val_i  (src_a_i),
    .amt_i  (shamt_i),
    .res_o  (shifted)
  );

  assign lt_bit = ctl.lt_unsigned ? lt_u : lt_s;

  always_comb begin
    case (ctl.rsel)
      RES_SUM:   res_d = sum;
      RES_AND:   res_d = src_a_i & opnd_b;
      RES_OR:    res_d = src_a_i | opnd_b;
      RES_NOR:   res_d = ~(src_a_i | opnd_b);
      RES_SHIFT: res_d = shifted;
      RES_LT:    res_d = {{(DATA_W-1){1'b0}}, lt_bit};
      RES_UPPER: res_d = {imm_i, {LOW_W{1'b0}}};
      default:   res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= res_d;
  end

endmodule

// File: rtl/ieu_chk.sv
module ieu_chk
  import ieu_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int IMM_W  = 16,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [SH_W-1:0]   shamt_i,
  input logic [DATA_W-1:0] result_o
);

  localparam int LOW_W = DATA_W - IMM_W;

  // R1: reset clears the result register
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> result_o == '0);

  // R4: zero-extended AND immediate cannot set upper bits
  p_andi_upper_r4: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_ANDI |=> result_o[DATA_W-1:IMM_W] == '0);

  // R6: arithmetic shift by the maximum count replicates the sign bit
  p_sra_full_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SRA && shamt_i == SH_W'(DATA_W-1))
      |=> result_o == {DATA_W{$past(src_a_i[DATA_W-1])}});

  // R7 / R8: every compare form yields only 0 or 1
  p_cmp_bool_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LTS || op_i == OP_LTU || op_i == OP_LTSI || op_i == OP_LTUI)
      |=> result_o[DATA_W-1:1] == '0);

  // R9: upper-immediate form: immediate on top, low half clear
  p_upper_r9: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_UPPER
      |=> (result_o[LOW_W-1:0] == '0) && (result_o[DATA_W-1:LOW_W] == $past(imm_i)));

  // R10: undefined codes give zero
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (rst)
    op_i > OP_W'(15) |=> result_o == '0);

endmodule

bind int_exec_unit ieu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .src_a_i  (src_a_i),
  .imm_i    (imm_i),
  .shamt_i  (shamt_i),
  .result_o (result_o)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  int_exec_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .imm_i    (imm_i),
    .shamt_i  (shamt_i),
    .result_o (result_o)
  );

  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] imm,
                                        input logic [4:0] sh);
    logic [31:0] se;
    logic [31:0] ze;
    se = {{16{imm[15]}}, imm};
    ze = {16'h0, imm};
    case (op)
      5'd0:    return a + b;
      5'd1:    return a - b;
      5'd2:    return a & b;
      5'd3:    return a | b;
      5'd4:    return ~(a | b);
      5'd5:    return a << sh;
      5'd6:    return a >> sh;
      5'd7:    return 32'($signed(a) >>> sh);
      5'd8:    return {31'h0, $signed(a) < $signed(b)};
      5'd9:    return {31'h0, a < b};
      5'd10:   return a + se;
      5'd11:   return a & ze;
      5'd12:   return a | ze;
      5'd13:   return {31'h0, $signed(a) < $signed(se)};
      5'd14:   return {31'h0, a < se};
      5'd15:   return {imm, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd10:  return "R2";
      5'd2, 5'd3, 5'd4:   return "R3";
      5'd11, 5'd12:       return "R4";
      5'd5, 5'd6:         return "R5";
      5'd7:               return "R6";
      5'd8, 5'd9:         return "R7";
      5'd13, 5'd14:       return "R8";
      5'd15:              return "R9";
      default:            return "R10";
    endcase
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    n_checks++;
    if (result_o !== exp) begin
      n_errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got %h expected %h",
               tag, op_i, src_a_i, src_b_i, imm_i, shamt_i, result_o, exp);
    end
  endtask

  // drive at a falling edge, result registered at the next rising edge, sample at the following fall
  task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] imm, input logic [4:0] sh, input string tag);
    @(negedge clk);
    op_i = op; src_a_i = a; src_b_i = b; imm_i = imm; shamt_i = sh;
    @(negedge clk);
    check(tag, model(op, a, b, imm, sh));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst = 1'b0;

    // R2 boundaries: wrap in both directions, negative immediate
    run(5'd0,  32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, "R2");
    run(5'd0,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, "R2");
    run(5'd1,  32'h0000_0000, 32'h0000_0001, 16'h0, 5'd0, "R2");
    run(5'd10, 32'h0000_0064, 32'h0, 16'hFFCE, 5'd0, "R2");
    run(5'd10, 32'h0000_0000, 32'h0, 16'h8000, 5'd0, "R2");
    // R3 bitwise
    run(5'd2, 32'h0000_3C00, 32'h0000_0DC0, 16'h0, 5'd0, "R3");
    run(5'd3, 32'h0000_3C00, 32'h0000_0DC0, 16'h0, 5'd0, "R3");
    run(5'd4, 32'h0F0F_0000, 32'h0000_00FF, 16'h0, 5'd0, "R3");
    // R4 zero extension with high immediate bit set
    run(5'd11, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, "R4");
    run(5'd12, 32'h0000_0000, 32'h0, 16'hFFFF, 5'd0, "R4");
    // R7 the signed/unsigned example and sign-crossing pairs
    run(5'd8, 32'hFFFF_FFFA, 32'h0000_FFFA, 16'h0, 5'd0, "R7");
    run(5'd9, 32'hFFFF_FFFA, 32'h0000_FFFA, 16'h0, 5'd0, "R7");
    run(5'd8, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, "R7");
    run(5'd9, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, "R7");
    run(5'd8, 32'h1234_5678, 32'h1234_5678, 16'h0, 5'd0, "R7");
    // R8 immediate compares with a negative immediate
    run(5'd13, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0, "R8");
    run(5'd14, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0, "R8");
    run(5'd13, 32'h8000_0000, 32'h0, 16'h0001, 5'd0, "R8");
    run(5'd14, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, "R8");
    // R9 upper immediate ignores both register operands
    run(5'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABAB, 5'd31, "R9");
    run(5'd15, 32'h0000_0000, 32'h0000_0000, 16'h0001, 5'd0, "R9");
    // R10 undefined codes with busy operands
    for (int k = 16; k < 32; k++)
      run(5'(k), 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'hFFFF, 5'd7, "R10");

    // R5 / R6 sweep every shift count on positive and negative words
    for (int s = 0; s < 32; s++) begin
      run(5'd5, 32'h1234_5678, 32'h0, 16'h0, 5'(s), "R5");
      run(5'd6, 32'h9234_5678, 32'h0, 16'h0, 5'(s), "R5");
      run(5'd7, 32'h9234_5678, 32'h0, 16'h0, 5'(s), "R6");
      run(5'd7, 32'h1234_5678, 32'h0, 16'h0, 5'(s), "R6");
    end

    // Pseudo-random pass over all codes, with equal-operand and edge pairs mixed in
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b, m;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      rng = next_rng(rng); m = rng;
      if (m[9:8] == 2'd0) b = a;
      if (m[11:10] == 2'd0) a = {32{m[12]}} ^ 32'h7FFF_FFFF;
      run(m[4:0], a, b, m[31:16], m[17:13], tag_of(m[4:0]));
    end

    // R1 mid-run reset after a nonzero result
    run(5'd3, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 5'd0, "R3");
    @(negedge clk);
    op_i = 5'd3; rst = 1'b1;
    @(negedge clk);
    check("R1", 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule